// File: doc/BRIEF.md
# Fetch-Triggered Pattern Bank Mapper

This block translates addresses for a cartridge-style system that has a CPU program bus and a separate pattern-memory bus driven by a picture processor. CPU writes into the upper half of the program space land in six registers, which are decoded from the top nibble of the address. One register picks the switchable 8 KB program bank. Four registers hold candidate 4 KB pattern banks, two for each pattern half. One register sets the nametable mirroring.

The picture processor changes pattern banks by itself. Each pattern half owns a two-state latch. A read strobe on certain tile-row addresses flips the latch, and the latch then chooses which of the half's two candidates drives the upper pattern address bits. The block outputs only the translated upper address bits and a mirroring level. The memory arrays sit outside it.

Top module: `fetch_latch_mapper`

## Requirements
- R1: After reset, the switchable program bank is 0. All four pattern candidates are 0. Both latches select their second candidate (the "E" state). Mirroring reads 0, which means vertical.
- R2: A write is decoded only from `cpu_addr[15:12]`. Nibbles 0x0 through 0x9 change no register, so `prg_addr`, `chr_addr` and `mirror_horiz` stay unchanged.
- R3: A write with nibble 0xA stores `cpu_wdata % PRG_BANKS` as the switchable bank. A read with `cpu_addr[14:13]` = 0 gives `prg_addr = {bank, cpu_addr[12:0]}`.
- R4: The window bank is fixed by `cpu_addr[14:13]`: 1 gives bank `PRG_BANKS-3`, 2 gives `PRG_BANKS-2`, and 3 gives `PRG_BANKS-1`. The low 13 bits pass through unchanged.
- R5: `ppu_addr[12]` picks the pattern half, and `chr_addr = {bank, ppu_addr[11:0]}`. Half 0 uses the nibble-0xB candidate in the D state and the nibble-0xC candidate in the E state. Half 1 uses the 0xD and 0xE candidates in the same way. Stored candidate values are `cpu_wdata % CHR_BANKS`.
- R6: When `ppu_rd` is high and `ppu_addr[13:4]` equals 0x0FD or 0x0FE, latch 0 moves to the D or E state. Tags 0x1FD and 0x1FE do the same for latch 1. The new state applies from the next cycle, so the triggering fetch still uses the old bank.
- R7: A trigger address seen while `ppu_rd` is low does not change either latch. A read at any other address does not change either latch.
- R8: A write with nibble 0xF stores `cpu_wdata[0]` into `mirror_horiz`, where 1 means horizontal.
- R9: A write to the candidate that the latch currently selects shows on `chr_addr` in the next cycle. A write to the unselected candidate is only stored and leaves `chr_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_rd | input | 1 | Pattern fetch strobe |
| ppu_addr | input | 14 | Pattern bus address |
| prg_addr | output | PRG_BW+13 | Translated program address |
| chr_addr | output | CHR_BW+12 | Translated pattern address |
| mirror_horiz | output | 1 | Mirroring: 1 horizontal, 0 vertical |

## Verification
The address translation is combinational. `prg_addr` and `chr_addr` follow the current `cpu_addr` and `ppu_addr` within the same cycle. Register writes and latch flips are captured at a rising edge and show on the outputs from the cycle after that edge.

The bench drives every input at the falling edge and samples all three outputs 1 ns later. A trigger fetch is therefore checked against the bank that was in place before it. Only after that sample does the bench apply the cycle's write or fetch to its reference model, so each result is expected exactly one edge after its stimulus.

// File: rtl/flm_pkg.sv
package flm_pkg;
   // Register select codes, taken from cpu_addr[15:12]
   typedef enum logic [3:0] {
      RG_PRG    = 4'hA,
      RG_H0_D   = 4'hB,
      RG_H0_E   = 4'hC,
      RG_H1_D   = 4'hD,
      RG_H1_E   = 4'hE,
      RG_MIRROR = 4'hF
   } reg_sel_e;

   // Fetch tag (ppu_addr[13:4]) that moves a half's latch into the D or E state
   function automatic logic [9:0] trig_tag(input logic half, input logic to_e);
      return {1'b0, half, 4'hF, (to_e ? 4'hE : 4'hD)};
   endfunction
endpackage

// File: rtl/prg_window_map.sv
module prg_window_map #(
   parameter int BANKS  = 16,
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [BANK_W-1:0] ld_bank,
   input  logic [14:0]       addr,
   output logic [BANK_W+12:0] prg_addr
);
   localparam logic [BANK_W-1:0] LAST = BANK_W'(BANKS - 1);

   logic [BANK_W-1:0] sw_q;
   logic [BANK_W-1:0] win_bank;

   always_ff @(posedge clk) begin
      if (!rst_n)  sw_q <= '0;
      else if (ld) sw_q <= ld_bank;
   end

   always_comb begin
      unique case (addr[14:13])
         2'd0:    win_bank = sw_q;
         2'd1:    win_bank = LAST - BANK_W'(2);
         2'd2:    win_bank = LAST - BANK_W'(1);
         default: win_bank = LAST;
      endcase
   end

   assign prg_addr = {win_bank, addr[12:0]};
endmodule

// File: rtl/chr_half_latch.sv
module chr_half_latch
   import flm_pkg::*;
#(
   parameter int BANK_W = 5,
   parameter bit HALF   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_d,
   input  logic              wr_e,
   input  logic [BANK_W-1:0] wbank,
   input  logic              ppu_rd,
   input  logic [9:0]        fetch_tag,
   output logic [BANK_W-1:0] bank,
   output logic              sel_e
);
   localparam logic [9:0] TAG_D = trig_tag(HALF, 1'b0);
   localparam logic [9:0] TAG_E = trig_tag(HALF, 1'b1);

   logic [BANK_W-1:0] cand_d, cand_e;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_d <= '0;
         cand_e <= '0;
         sel_e  <= 1'b1;
      end else begin
         if (wr_d) cand_d <= wbank;
         if (wr_e) cand_e <= wbank;
         if (ppu_rd) begin
            if (fetch_tag == TAG_D)      sel_e <= 1'b0;
            else if (fetch_tag == TAG_E) sel_e <= 1'b1;
         end
      end
   end

   assign bank = sel_e ? cand_e : cand_d;
endmodule

// File: rtl/fetch_latch_mapper.sv
module fetch_latch_mapper
   import flm_pkg::*;
#(
   parameter int PRG_BANKS = 16,
   parameter int CHR_BANKS = 24,
   localparam int PRG_BW = $clog2(PRG_BANKS),
   localparam int CHR_BW = $clog2(CHR_BANKS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_wr,
   input  logic [15:0]         cpu_addr,
   input  logic [7:0]          cpu_wdata,
   input  logic                ppu_rd,
   input  logic [13:0]         ppu_addr,
   output logic [PRG_BW+12:0]  prg_addr,
   output logic [CHR_BW+11:0]  chr_addr,
   output logic                mirror_horiz
);
   localparam logic [7:0] PRG_MOD = 8'(PRG_BANKS);
   localparam logic [7:0] CHR_MOD = 8'(CHR_BANKS);

   if (PRG_BANKS < 3 || PRG_BANKS > 255) begin : g_bad_prg
      $error("PRG_BANKS must be in 3..255");
   end
   if (CHR_BANKS < 2 || CHR_BANKS > 255) begin : g_bad_chr
      $error("CHR_BANKS must be in 2..255");
   end

   logic [3:0]        sel;
   logic              wr_prg, wr_mir;
   logic [1:0]        wr_d, wr_e;
   logic [PRG_BW-1:0] prg_red;
   logic [CHR_BW-1:0] chr_red;
   logic [CHR_BW-1:0] half_bank [2];
   logic [1:0]        st_fe;

   assign sel     = cpu_addr[15:12];
   assign wr_prg  = cpu_wr && (sel == RG_PRG);
   assign wr_mir  = cpu_wr && (sel == RG_MIRROR);
   assign wr_d[0] = cpu_wr && (sel == RG_H0_D);
   assign wr_e[0] = cpu_wr && (sel == RG_H0_E);
   assign wr_d[1] = cpu_wr && (sel == RG_H1_D);
   assign wr_e[1] = cpu_wr && (sel == RG_H1_E);

   assign prg_red = PRG_BW'(cpu_wdata % PRG_MOD);
   assign chr_red = CHR_BW'(cpu_wdata % CHR_MOD);

   prg_window_map #(.BANKS(PRG_BANKS), .BANK_W(PRG_BW)) u_prg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (wr_prg),
      .ld_bank  (prg_red),
      .addr     (cpu_addr[14:0]),
      .prg_addr (prg_addr)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      chr_half_latch #(.BANK_W(CHR_BW), .HALF(h[0])) u_lat (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_d      (wr_d[h]),
         .wr_e      (wr_e[h]),
         .wbank     (chr_red),
         .ppu_rd    (ppu_rd),
         .fetch_tag (ppu_addr[13:4]),
         .bank      (half_bank[h]),
         .sel_e     (st_fe[h])
      );
   end

   assign chr_addr = {half_bank[ppu_addr[12]], ppu_addr[11:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)      mirror_horiz <= 1'b0;
      else if (wr_mir) mirror_horiz <= cpu_wdata[0];
   end
endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
   parameter int PRG_BANKS = 16,
   parameter int PRG_BW    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic [15:0]       cpu_addr,
   input logic              wd0,
   input logic              ppu_rd,
   input logic [9:0]        ppu_tag,
   input logic [PRG_BW+12:0] prg_addr,
   input logic              mirror_horiz,
   input logic [1:0]        st_fe
);
   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (st_fe == 2'b11 && !mirror_horiz));

   a_r6_low_to_d: assert property (@(posedge clk) disable iff (!rst_n)
      (ppu_rd && ppu_tag == 10'h0FD) |=> !st_fe[0]);

   a_r6_high_to_e: assert property (@(posedge clk) disable iff (!rst_n)
      (ppu_rd && ppu_tag == 10'h1FE) |=> st_fe[1]);

   a_r7_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ppu_rd |=> $stable(st_fe));

   a_r4_last_window: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b111) |->
         (prg_addr == {PRG_BW'(PRG_BANKS - 1), cpu_addr[12:0]}));

   a_r8_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:12] == 4'hF) |=> (mirror_horiz == $past(wd0)));
endmodule

bind fetch_latch_mapper flm_checker #(.PRG_BANKS(PRG_BANKS), .PRG_BW(PRG_BW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_wr       (cpu_wr),
   .cpu_addr     (cpu_addr),
   .wd0          (cpu_wdata[0]),
   .ppu_rd       (ppu_rd),
   .ppu_tag      (ppu_addr[13:4]),
   .prg_addr     (prg_addr),
   .mirror_horiz (mirror_horiz),
   .st_fe        (st_fe)
);

// File: tb/fetch_latch_mapper_tb.sv
module fetch_latch_mapper_tb;
   localparam int PB = 16;
   localparam int CB = 24;
   localparam int PW = $clog2(PB);
   localparam int CW = $clog2(CB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic ppu_rd = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic [PW+12:0] prg_addr;
   logic [CW+11:0] chr_addr;
   logic mirror_horiz;

   int checks = 0;
   int fails = 0;

   // reference model
   int m_prg = 0;
   int m_cand [4] = '{0, 0, 0, 0};
   bit m_fe [2] = '{1'b1, 1'b1};
   bit m_mir = 1'b0;

   always #4 clk = ~clk;

   fetch_latch_mapper #(.PRG_BANKS(PB), .CHR_BANKS(CB)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
      .prg_addr(prg_addr), .chr_addr(chr_addr), .mirror_horiz(mirror_horiz)
   );

   function automatic int exp_prg(input logic [15:0] ca);
      int w = int'(ca[14:13]);
      int b = (w == 0) ? m_prg : PB - 4 + w;
      return (b << 13) | int'(ca[12:0]);
   endfunction

   function automatic int exp_chr(input logic [13:0] pa);
      int h = int'(pa[12]);
      int b = m_fe[h] ? m_cand[2*h+1] : m_cand[2*h];
      return (b << 12) | int'(pa[11:0]);
   endfunction

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit wr, input logic [15:0] ca, input logic [7:0] wd,
                      input bit rd, input logic [13:0] pa, input string tag);
      @(negedge clk);
      cpu_wr = wr; cpu_addr = ca; cpu_wdata = wd; ppu_rd = rd; ppu_addr = pa;
      #1;
      check(int'(prg_addr), exp_prg(ca), (ca[14:13] == 2'd0) ? "R3" : "R4");
      check(int'(chr_addr), exp_chr(pa), tag);
      check(int'(mirror_horiz), int'(m_mir), "R8");
      // state changes captured at the coming edge
      if (wr) begin
         case (ca[15:12])
            4'hA: m_prg = int'(wd) % PB;
            4'hB: m_cand[0] = int'(wd) % CB;
            4'hC: m_cand[1] = int'(wd) % CB;
            4'hD: m_cand[2] = int'(wd) % CB;
            4'hE: m_cand[3] = int'(wd) % CB;
            4'hF: m_mir = wd[0];
            default: ; // R2: ignored
         endcase
      end
      if (rd) begin
         case (pa[13:4])
            10'h0FD: m_fe[0] = 1'b0;
            10'h0FE: m_fe[0] = 1'b1;
            10'h1FD: m_fe[1] = 1'b0;
            10'h1FE: m_fe[1] = 1'b1;
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values, low half selects candidate C (=0)
      cyc(0, 16'h8000, 8'h00, 0, 14'h0010, "R1");
      cyc(1, 16'hB000, 8'd5,  0, 14'h0020, "R1");
      // R9: unselected candidate stored only
      cyc(0, 16'h8100, 8'h00, 0, 14'h0020, "R9");
      cyc(1, 16'hC123, 8'd31, 0, 14'h0030, "R9");
      cyc(0, 16'h8200, 8'h00, 0, 14'h0030, "R9"); // 31 % 24 = 7
      // R6: trigger fetch still uses old bank, next uses D candidate
      cyc(0, 16'h8000, 8'h00, 1, 14'h0FD5, "R6");
      cyc(0, 16'h8000, 8'h00, 1, 14'h0100, "R6");
      // R7: trigger without strobe ignored
      cyc(0, 16'h8000, 8'h00, 0, 14'h0FE2, "R7");
      cyc(0, 16'h8000, 8'h00, 1, 14'h0200, "R7");
      // R7: near-miss address with strobe ignored
      cyc(0, 16'h8000, 8'h00, 1, 14'h0FC7, "R7");
      cyc(0, 16'h8000, 8'h00, 1, 14'h2FE0, "R7");
      cyc(0, 16'h8000, 8'h00, 0, 14'h0300, "R7");
      // R9: selected candidate visible next cycle
      cyc(1, 16'hB777, 8'd50, 0, 14'h0300, "R9");
      cyc(0, 16'h8000, 8'h00, 0, 14'h0300, "R9"); // 50 % 24 = 2
      // R2: unmapped nibbles change nothing
      cyc(1, 16'h5F00, 8'hFF, 0, 14'h0300, "R2");
      cyc(1, 16'h9000, 8'hFF, 0, 14'h0300, "R2");
      cyc(0, 16'h8ABC, 8'h00, 0, 14'h0300, "R2");
      // R3: program bank modulo
      cyc(1, 16'hAFFF, 8'h13, 0, 14'h0000, "R3");
      cyc(0, 16'h8ABC, 8'h00, 0, 14'h0000, "R3");
      cyc(1, 16'hA000, 8'hFF, 0, 14'h0000, "R3");
      cyc(0, 16'h9FFF, 8'h00, 0, 14'h0000, "R3");
      // R4: fixed windows
      cyc(0, 16'hA123, 8'h00, 0, 14'h0000, "R4");
      cyc(0, 16'hC456, 8'h00, 0, 14'h0000, "R4");
      cyc(0, 16'hFFFF, 8'h00, 0, 14'h0000, "R4");
      // R8: mirroring
      cyc(1, 16'hF000, 8'h01, 0, 14'h0000, "R8");
      cyc(1, 16'hF555, 8'h02, 0, 14'h0000, "R8");
      cyc(0, 16'h8000, 8'h00, 0, 14'h0000, "R8");
      // R5: upper half, modulo, then R6 flip of latch 1
      cyc(1, 16'hE000, 8'd30, 0, 14'h1234, "R5");
      cyc(1, 16'hD000, 8'd9,  0, 14'h1234, "R5");
      cyc(0, 16'h8000, 8'h00, 1, 14'h1FD7, "R6");
      cyc(0, 16'h8000, 8'h00, 1, 14'h1000, "R6");
      cyc(0, 16'h8000, 8'h00, 1, 14'h1FEF, "R6");
      cyc(0, 16'h8000, 8'h00, 0, 14'h1FFF, "R6");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [13:0] pa;
         logic [3:0] r = 4'($urandom);
         case ($urandom % 6)
            0: pa = {10'h0FD, r};
            1: pa = {10'h0FE, r};
            2: pa = {10'h1FD, r};
            3: pa = {10'h1FE, r};
            default: pa = 14'($urandom);
         endcase
         cyc(($urandom % 4) == 0, 16'($urandom), 8'($urandom),
             ($urandom % 4) != 0, pa, "R5");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule